// File: doc/BRIEF.md
# Shadow Stack Push/Pop Unit

This unit owns the shadow stack pointer of one hart and carries out the two operations that maintain a protected return-address stack: push and pop-with-check. A push moves the pointer down by one machine word, stores the operand at the new location, and adopts that location as the pointer. A pop-with-check reads the word at the pointer and compares it against the operand. If they are equal, the pointer moves up by one word. If they differ, a software-check exception is raised.

Operations enter on a valid/ready handshake, and the unit runs only one at a time. Memory accesses leave on a valid/ready request channel. The memory answers on a response channel that has no back-pressure, and the unit accepts one response per request. Whether the operation really happens depends on the privilege level, the virtualization bit and three enable bits (machine, hypervisor and supervisor level). When it is not allowed, the operation retires as a no-op. A simple write port lets the control-register path load the pointer.

Back-pressure rules:
- `op_ready` is high only while the unit is idle. An operation transfers on a cycle where `op_valid` and `op_ready` are both high.
- Once `mem_req_valid` rises, the address, data and write flag stay fixed until the cycle where `mem_req_ready` is high.
- `mem_rsp_valid` must be high for exactly one cycle per accepted request.

Top module: `ss_stack_unit`

## Requirements
- R1: After reset the pointer reads 0, `op_ready` is 1, and both `mem_req_valid` and `done` are 0.
- R2: When `ptr_we` is high, the pointer takes `ptr_wdata` with its low log2(XLEN/8) bits cleared. The new value is visible on `ptr_value` in the next cycle.
- R3: A push issues a write (`mem_we`=1) of `op_value` at pointer − XLEN/8, where the subtraction wraps modulo 2^XLEN. After a fault-free response, the pointer equals that address in the cycle after `done`.
- R4: A pop issues a read (`mem_we`=0) at the pointer. If the returned word equals `op_value`, the operation retires with no exception and the pointer grows by XLEN/8.
- R5: If a pop returns a word that differs from `op_value`, the unit reports `exc_valid`=1 with `exc_cause`=2 (software check) and `exc_tval`=3. The pointer is left unchanged.
- R6: The operation is active only when all of these hold:
  - `priv` is not 11.
  - `en_m` is 1.
  - `virt` is 0, or `en_h` is 1.
  - `priv` is not 00, or `en_s` is 1.

  The encodings of `priv` are 00 user, 01 supervisor and 11 machine. The value 10 is handled as supervisor.
- R7: An inactive operation makes no memory request, changes no pointer and raises no exception. `done` rises in the cycle after acceptance.
- R8: A response with `mem_rsp_err`=1, for a push or for a pop, gives `exc_cause`=1 (store access fault) with `exc_tval` equal to the access address. The pointer is left unchanged.
- R9: If a pointer write and a completing operation's pointer update fall in the same cycle, the operation's update wins.
- R10: `op_ready` stays 0 from acceptance until the cycle after `done`. A stalled memory request holds its valid, address and data stable.
- R11: `done` is a single-cycle pulse. `exc_valid` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle and able to take an operation |
| op_is_pop | input | 1 | 1 = pop-with-check, 0 = push |
| op_value | input | XLEN | Push data or pop compare value |
| priv | input | 2 | Privilege level of the operation |
| virt | input | 1 | Virtualized execution |
| en_m | input | 1 | Machine-level enable |
| en_h | input | 1 | Hypervisor-level enable |
| en_s | input | 1 | Supervisor-level enable (gates user mode) |
| ptr_we | input | 1 | Pointer write strobe |
| ptr_wdata | input | XLEN | Pointer write data |
| ptr_value | output | XLEN | Current pointer |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Store data |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | XLEN | Load data |
| mem_rsp_err | input | 1 | Access faulted |
| done | output | 1 | Operation retired |
| exc_valid | output | 1 | Exception on this retirement |
| exc_cause | output | 2 | 1 store access fault, 2 software check |
| exc_tval | output | XLEN | Trap value |

## Verification
Two actions can meet in the same clock edge: a pointer write from the control-register path, and the pointer update of an operation that is retiring. The bench provokes this by driving `ptr_we` with an unaligned value during the cycle in which `done` is high. It then requires that the next `ptr_value` is the push address and not the written value. A sweep over all 64 combinations of privilege, virtualization and the three enables also counts the memory accesses. This confirms that gated operations never reach memory and that the pointer moves only when the operation is enabled.

// File: rtl/ss_unit_pkg.sv
package ss_unit_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_CHECK} ss_state_e;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0, EXC_STORE_ACCESS = 2'd1, EXC_SW_CHECK = 2'd2
  } ss_exc_e;
  localparam logic [1:0] PRIV_USER    = 2'b00;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;
  localparam int unsigned SW_CHECK_TVAL = 3;
endpackage

// File: rtl/ss_enable.sv
module ss_enable
  import ss_unit_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       en_m,
  input  logic       en_h,
  input  logic       en_s,
  output logic       active
);
  logic not_machine, virt_ok, user_ok;
  always_comb begin
    not_machine = (priv != PRIV_MACHINE);
    virt_ok     = !virt || en_h;
    user_ok     = (priv != PRIV_USER) || en_s;
    active      = not_machine && en_m && virt_ok && user_ok;
  end
endmodule

// File: rtl/ss_ptr_reg.sv
module ss_ptr_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            upd_en,
  input  logic [XLEN-1:0] upd_val,
  output logic [XLEN-1:0] ptr
);
  localparam int BYTES = XLEN / 8;
  localparam logic [XLEN-1:0] MASK = ~(XLEN'(BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (upd_en) ptr <= upd_val & MASK;
    else if (csr_we) ptr <= csr_wdata & MASK;
  end

  // R9
  upd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> ptr == ($past(upd_val) & MASK));
  // R2
  csr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !upd_en) |=> ptr == ($past(csr_wdata) & MASK));
endmodule

// File: rtl/ss_seq.sv
module ss_seq
  import ss_unit_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic            op_is_pop,
  input  logic [XLEN-1:0] op_value,
  input  logic            active,
  input  logic [XLEN-1:0] ptr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  input  logic            mem_rsp_err,
  output logic            upd_en,
  output logic [XLEN-1:0] upd_val,
  output logic            done,
  output logic            exc_valid,
  output logic [1:0]      exc_cause,
  output logic [XLEN-1:0] exc_tval
);
  localparam int BYTES = XLEN / 8;
  localparam logic [XLEN-1:0] STEP = XLEN'(BYTES);
  localparam logic [XLEN-1:0] TVAL_SW = XLEN'(SW_CHECK_TVAL);

  ss_state_e state_q;
  logic            pop_q, noop_q, err_q;
  logic [XLEN-1:0] val_q, addr_q, data_q;
  logic            mismatch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pop_q   <= 1'b0;
      noop_q  <= 1'b0;
      err_q   <= 1'b0;
      val_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (op_valid) begin
          pop_q   <= op_is_pop;
          val_q   <= op_value;
          noop_q  <= !active;
          err_q   <= 1'b0;
          addr_q  <= op_is_pop ? ptr : ptr - STEP;
          state_q <= active ? ST_REQ : ST_CHECK;
        end
        ST_REQ:  if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          data_q  <= mem_rsp_data;
          err_q   <= mem_rsp_err;
          state_q <= ST_CHECK;
        end
        ST_CHECK: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    op_ready      = (state_q == ST_IDLE);
    mem_req_valid = (state_q == ST_REQ);
    mem_addr      = addr_q;
    mem_wdata     = val_q;
    mem_we        = !pop_q;
    done          = (state_q == ST_CHECK);
    mismatch      = !noop_q && !err_q && pop_q && (data_q != val_q);
    exc_valid     = done && !noop_q && (err_q || mismatch);
    exc_cause     = !exc_valid ? EXC_NONE : (err_q ? EXC_STORE_ACCESS : EXC_SW_CHECK);
    exc_tval      = err_q ? addr_q : TVAL_SW;
    upd_en        = done && !noop_q && !err_q && !mismatch;
    upd_val       = pop_q ? addr_q + STEP : addr_q;
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));
  // R11
  exc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> done);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> !op_ready);
  // R7
  noop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_valid && op_ready) && done) |-> (!upd_en && !exc_valid));
endmodule

// File: rtl/ss_stack_unit.sv
module ss_stack_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic            op_is_pop,
  input  logic [XLEN-1:0] op_value,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            en_m,
  input  logic            en_h,
  input  logic            en_s,
  input  logic            ptr_we,
  input  logic [XLEN-1:0] ptr_wdata,
  output logic [XLEN-1:0] ptr_value,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  input  logic            mem_rsp_err,
  output logic            done,
  output logic            exc_valid,
  output logic [1:0]      exc_cause,
  output logic [XLEN-1:0] exc_tval
);
  logic            active;
  logic            upd_en;
  logic [XLEN-1:0] upd_val;

  ss_enable u_enable (
    .priv(priv), .virt(virt), .en_m(en_m), .en_h(en_h), .en_s(en_s),
    .active(active)
  );

  ss_ptr_reg #(.XLEN(XLEN)) u_ptr (
    .clk(clk), .rst_n(rst_n), .csr_we(ptr_we), .csr_wdata(ptr_wdata),
    .upd_en(upd_en), .upd_val(upd_val), .ptr(ptr_value)
  );

  ss_seq #(.XLEN(XLEN)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_is_pop(op_is_pop), .op_value(op_value),
    .active(active), .ptr(ptr_value),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .upd_en(upd_en), .upd_val(upd_val),
    .done(done), .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval)
  );

  // R5
  swcheck_tval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_cause == 2'd2) |-> exc_tval == XLEN'(3));
  // R6
  mach_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && priv == 2'b11) |=> (done && !mem_req_valid));
endmodule

// File: tb/ss_stack_unit_tb.sv
module ss_stack_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic op_valid = 0, op_is_pop = 0;
  logic [31:0] op_value = 0;
  logic [1:0] priv = 2'b01;
  logic virt = 0, en_m = 1, en_h = 0, en_s = 0;
  logic ptr_we = 0;
  logic [31:0] ptr_wdata = 0;
  logic mem_req_ready = 0, mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [31:0] mem_rsp_data = 0;
  wire op_ready, mem_req_valid, mem_we, done, exc_valid;
  wire [31:0] ptr_value, mem_addr, mem_wdata, exc_tval;
  wire [1:0] exc_cause;

  int checks = 0, fails = 0;
  logic [31:0] mem [16];
  int stall_cycles = 0, stall_cnt = 0, acc_count = 0;
  bit inj_err = 0, rsp_pend = 0, rsp_err_n = 0;
  logic [31:0] rsp_data_n = 0, last_addr = 0;
  bit last_we = 0;

  ss_stack_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_is_pop(op_is_pop), .op_value(op_value), .priv(priv), .virt(virt),
    .en_m(en_m), .en_h(en_h), .en_s(en_s), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .ptr_value(ptr_value), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .done(done), .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: inputs change on the falling edge only
  always @(negedge clk) begin
    mem_rsp_valid = 0;
    mem_req_ready = 0;
    if (rsp_pend) begin
      mem_rsp_valid = 1; mem_rsp_data = rsp_data_n; mem_rsp_err = rsp_err_n; rsp_pend = 0;
    end else if (mem_req_valid) begin
      if (stall_cnt < stall_cycles) stall_cnt++;
      else begin
        stall_cnt = 0; mem_req_ready = 1; acc_count++;
        last_addr = mem_addr; last_we = mem_we;
        rsp_err_n = inj_err; rsp_data_n = mem[mem_addr[5:2]];
        if (mem_we && !inj_err) mem[mem_addr[5:2]] = mem_wdata;
        rsp_pend = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_ptr(input logic [31:0] v);
    @(negedge clk); ptr_we = 1; ptr_wdata = v;
    @(negedge clk); ptr_we = 0;
  endtask

  // returns at the falling edge in the cycle after done
  task automatic run_op(input bit pop, input logic [31:0] v, input bit clash,
                        input logic [31:0] clash_val, output bit ready_busy,
                        output bit ex, output logic [1:0] cause, output logic [31:0] tval);
    int n;
    @(negedge clk); op_valid = 1; op_is_pop = pop; op_value = v;
    @(negedge clk); op_valid = 0;
    ready_busy = op_ready;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    ex = exc_valid; cause = exc_cause; tval = exc_tval;
    if (clash) begin ptr_we = 1; ptr_wdata = clash_val; end
    @(negedge clk);
    ptr_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit rb, ex;
    logic [1:0] cause;
    logic [31:0] tval, p0;
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(ptr_value == 0, "R1", "ptr", ptr_value, 0);
    chk(op_ready == 1, "R1", "op_ready", {31'b0, op_ready}, 1);
    chk(!mem_req_valid && !done, "R1", "req/done", {30'b0, mem_req_valid, done}, 0);

    // R2 alignment of pointer writes
    set_ptr(32'h43);
    chk(ptr_value == 32'h40, "R2", "ptr", ptr_value, 32'h40);
    set_ptr(32'h3F);
    chk(ptr_value == 32'h3C, "R2", "ptr", ptr_value, 32'h3C);
    set_ptr(32'h40);

    // R3 pushes with varying stall
    for (int i = 0; i < 5; i++) begin
      logic [31:0] v;
      v = 32'hA000_0000 + i * 32'h111;
      p0 = ptr_value;
      stall_cycles = i % 3;
      run_op(0, v, 0, 0, rb, ex, cause, tval);
      chk(rb == 0, "R10", "op_ready while busy", {31'b0, rb}, 0);
      chk(last_addr == p0 - 4 && last_we, "R3", "push addr", last_addr, p0 - 4);
      chk(mem[(p0 - 4) >> 2 & 15] == v, "R3", "stored word", mem[(p0 - 4) >> 2 & 15], v);
      chk(ptr_value == p0 - 4 && !ex, "R3", "ptr after push", ptr_value, p0 - 4);
    end
    // R4 matching pops in reverse
    for (int i = 4; i >= 0; i--) begin
      logic [31:0] v;
      v = 32'hA000_0000 + i * 32'h111;
      p0 = ptr_value;
      stall_cycles = (i + 1) % 3;
      run_op(1, v, 0, 0, rb, ex, cause, tval);
      chk(last_addr == p0 && !last_we, "R4", "pop addr", last_addr, p0);
      chk(!ex, "R4", "no exception", {31'b0, ex}, 0);
      chk(ptr_value == p0 + 4, "R4", "ptr after pop", ptr_value, p0 + 4);
    end
    stall_cycles = 0;

    // R5 mismatch
    run_op(0, 32'h1111_2222, 0, 0, rb, ex, cause, tval);
    p0 = ptr_value;
    run_op(1, 32'h1111_2223, 0, 0, rb, ex, cause, tval);
    chk(ex && cause == 2, "R5", "cause", {30'b0, cause}, 2);
    chk(tval == 3, "R5", "tval", tval, 3);
    chk(ptr_value == p0, "R5", "ptr kept", ptr_value, p0);
    run_op(1, 32'h1111_2222, 0, 0, rb, ex, cause, tval);

    // R8 faulting accesses
    inj_err = 1;
    p0 = ptr_value;
    run_op(0, 32'h5555_5555, 0, 0, rb, ex, cause, tval);
    chk(ex && cause == 1, "R8", "push cause", {30'b0, cause}, 1);
    chk(tval == p0 - 4, "R8", "push tval", tval, p0 - 4);
    chk(ptr_value == p0, "R8", "push ptr kept", ptr_value, p0);
    run_op(1, 32'h0, 0, 0, rb, ex, cause, tval);
    chk(ex && cause == 1, "R8", "pop cause", {30'b0, cause}, 1);
    chk(tval == p0, "R8", "pop tval", tval, p0);
    chk(ptr_value == p0, "R8", "pop ptr kept", ptr_value, p0);
    inj_err = 0;

    // R6 / R7 sweep over every gating combination
    for (int c = 0; c < 64; c++) begin
      int a0;
      bit exp_en;
      priv = c[1:0]; virt = c[2]; en_m = c[3]; en_h = c[4]; en_s = c[5];
      exp_en = (priv != 2'b11) && en_m && (!virt || en_h) && (priv != 2'b00 || en_s);
      p0 = ptr_value; a0 = acc_count;
      run_op(0, 32'hC0DE_0000 + c, 0, 0, rb, ex, cause, tval);
      chk((acc_count - a0) == int'(exp_en), "R7", "access count",
          acc_count - a0, {31'b0, exp_en});
      chk(ptr_value == (exp_en ? p0 - 4 : p0) && !ex, "R6", "ptr after gated push",
          ptr_value, exp_en ? p0 - 4 : p0);
      a0 = acc_count;
      run_op(1, 32'hC0DE_0000 + c, 0, 0, rb, ex, cause, tval);
      chk(ptr_value == p0 && !ex && (acc_count - a0) == int'(exp_en), "R7",
          "ptr after gated pop", ptr_value, p0);
    end
    priv = 2'b01; virt = 0; en_m = 1; en_h = 0; en_s = 0;

    // R9 pointer write collides with retirement
    p0 = ptr_value;
    run_op(0, 32'h9999_0000, 1, 32'h0000_0033, rb, ex, cause, tval);
    chk(ptr_value == p0 - 4, "R9", "update wins", ptr_value, p0 - 4);
    run_op(1, 32'h9999_0000, 0, 0, rb, ex, cause, tval);

    // R3 wrap below zero
    set_ptr(32'h0);
    run_op(0, 32'h1234, 0, 0, rb, ex, cause, tval);
    chk(last_addr == 32'hFFFF_FFFC, "R3", "wrap addr", last_addr, 32'hFFFF_FFFC);
    chk(ptr_value == 32'hFFFF_FFFC, "R3", "wrap ptr", ptr_value, 32'hFFFF_FFFC);
    run_op(1, 32'h1234, 0, 0, rb, ex, cause, tval);
    chk(ptr_value == 0 && !ex, "R4", "wrap pop", ptr_value, 0);
    // R11 done returns low
    chk(!done && !exc_valid, "R11", "done pulse", {30'b0, done, exc_valid}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule